// File: doc/BRIEF.md
# Device Power State Sequencer

This block follows the power-management state of a peripheral function through four stages. The function works normally in the active state. Software can park it in a low-power sleep state. On the way back it passes through a configuration reload and then an uninitialized state. The block watches software writes to a 2-bit power state field and to the memory and I/O access enable bits of a command register. From these it drives the handshake to a nonvolatile-memory (NVM) reader, the PHY reset, the PHY power mode and the link power state it requests.

Leaving sleep always starts an NVM read, and the PHY is held in reset until that read finishes. The two bits the read returns are a wake enable and a sideband management enable. They decide whether the PHY idles at reduced speed or stays powered down until software grants memory or I/O access again. Only that grant brings the PHY back to full power. The block has no timers: software can stay as long as it likes in sleep and in the uninitialized state.

Top module: `pwr_state_seq`

## Requirements
- R1: A synchronous active-low reset gives `pwrState` = 2'b11 (uninitialized), `phyRst` = 1, `phyMode` = 2'b00 (off), `linkL1` = 0 and `nvmStart` = 0.
- R2: In the first cycle after reset is released, `nvmStart` pulses for one cycle. Access-enable writes are ignored until `nvmDone` arrives. That `nvmDone` latches the two NVM bits and clears `phyRst`.
- R3: A power state write of 2'b11 while `pwrState` = 2'b00 (active) moves the block to 2'b01 (sleep) on the next cycle, and `linkL1` becomes 1.
- R4: In sleep, only a power state write of 2'b00 leaves. It moves the block to 2'b10 (reading NVM) and raises `nvmStart` for exactly one cycle on entry. In that state `phyRst` = 1 and `linkL1` = 0. Sleep has no timeout.
- R5: While reading, the state holds and `phyRst` stays 1 until `nvmDone`. The cycle after `nvmDone`, the state is 2'b11 and `phyRst` = 0.
- R6: In the uninitialized state with reset released, `phyMode` is 2'b01 (reduced speed) if either latched NVM bit is 1 and 2'b00 (off) otherwise. The block waits there for any length of time.
- R7: In the uninitialized state, with no read pending, a command write with the memory or I/O enable bit set moves the block to active. There `phyMode` = 2'b10 (full) and `phyRst` = 0. A command write with both bits clear does nothing.
- R8: Power state writes of 2'b01 or 2'b10 are ignored. A write of 2'b11 outside active is ignored, and so is a write of 2'b00 outside sleep. Command writes are ignored outside the uninitialized state.
- R9: In sleep, `phyMode` is 2'b01 if either bit of the most recently latched NVM result is 1, else 2'b00.
- R10: `nvmDone` is ignored unless a read is pending: it neither changes the state nor replaces the latched NVM bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| cfgWrValid | input | 1 | One-cycle strobe: power state field written |
| cfgWrState | input | 2 | Value written to the power state field |
| cmdWrValid | input | 1 | One-cycle strobe: command register written |
| cmdMemEn | input | 1 | Memory access enable bit of the command write |
| cmdIoEn | input | 1 | I/O access enable bit of the command write |
| nvmStart | output | 1 | One-cycle request to read NVM configuration |
| nvmDone | input | 1 | NVM read finished; result bits valid |
| nvmWakeEn | input | 1 | NVM result: wake-up enabled |
| nvmSideEn | input | 1 | NVM result: sideband management enabled |
| phyRst | output | 1 | PHY reset, active high |
| phyMode | output | 2 | PHY power: 00 off, 01 reduced speed, 10 full |
| linkL1 | output | 1 | Requested link state: 1 = L1, 0 = L0 |
| pwrState | output | 2 | 00 active, 01 sleep, 10 reading NVM, 11 uninitialized |

## Verification
Assertions check on every cycle that a power state write of 11 in active leads to sleep, and that sleep holds until a 00 write, which leads to the read state. They also check that `nvmStart` never lasts two cycles, that the PHY reset is high whenever the read state is shown and low whenever the block is active, and that the uninitialized state holds without a command write. The bench's scenarios show what depends on data and history: which writes are ignored in each state, the PHY mode chosen from the latched NVM bits in sleep and after the reload, access-enable writes blocked while the first read after reset is pending, and stray `nvmDone` pulses that must leave the latched bits unchanged.

// File: rtl/pss_pkg.sv
package pss_pkg;

  localparam int STATE_W = 2;
  localparam int MODE_W  = 2;

  typedef enum logic [STATE_W-1:0] {
    PS_D0A  = 2'b00,
    PS_D3   = 2'b01,
    PS_READ = 2'b10,
    PS_D0U  = 2'b11
  } pwrState_e;

  typedef enum logic [MODE_W-1:0] {
    PHY_OFF  = 2'b00,
    PHY_LOW  = 2'b01,
    PHY_FULL = 2'b10
  } phyMode_e;

  localparam logic [STATE_W-1:0] WR_WAKE  = 2'b00;
  localparam logic [STATE_W-1:0] WR_SLEEP = 2'b11;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic startRead;
    logic latchNvm;
    logic assertRst;
    logic releaseRst;
  } seqStrobe_t;

endpackage

// File: rtl/pss_ctrl.sv
module pss_ctrl
  import pss_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrValid,
  input  logic [STATE_W-1:0] cfgWrState,
  input  logic               cmdWrValid,
  input  logic               cmdMemEn,
  input  logic               cmdIoEn,
  input  logic               nvmDone,
  output pwrState_e          curState,
  output seqStrobe_t         strb
);

  pwrState_e stateQ, stateD;
  logic      pendQ;   // first read after reset not yet completed
  logic      kickQ;   // issue the initial read request after reset

  logic sleepReq, wakeReq, accessReq, nvmAccept;

  always_comb begin
    sleepReq  = cfgWrValid && (cfgWrState == WR_SLEEP);
    wakeReq   = cfgWrValid && (cfgWrState == WR_WAKE);
    accessReq = cmdWrValid && (cmdMemEn || cmdIoEn);
    nvmAccept = nvmDone && ((stateQ == PS_READ) || pendQ);
  end

  always_comb begin
    stateD = stateQ;
    strb   = '0;
    strb.startRead  = kickQ;
    strb.latchNvm   = nvmAccept;
    strb.releaseRst = nvmAccept;
    unique case (stateQ)
      PS_D0A: begin
        if (sleepReq) stateD = PS_D3;
      end
      PS_D3: begin
        if (wakeReq) begin
          stateD         = PS_READ;
          strb.startRead = 1'b1;
          strb.assertRst = 1'b1;
        end
      end
      PS_READ: begin
        if (nvmAccept) stateD = PS_D0U;
      end
      PS_D0U: begin
        if (accessReq && !pendQ) stateD = PS_D0A;
      end
      default: stateD = PS_D0U;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= PS_D0U;
      pendQ  <= 1'b1;
      kickQ  <= 1'b1;
    end else begin
      stateQ <= stateD;
      kickQ  <= 1'b0;
      if (nvmAccept) pendQ <= 1'b0;
    end
  end

  assign curState = stateQ;

  AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == PS_D0A && sleepReq) |=> (stateQ == PS_D3)); // R3

  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == PS_D3 && !wakeReq) |=> (stateQ == PS_D3)); // R4

  AST_SLEEP_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == PS_D3 && wakeReq) |=> (stateQ == PS_READ)); // R4

  AST_UNINIT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == PS_D0U && !cmdWrValid) |=> (stateQ == PS_D0U)); // R6

endmodule

// File: rtl/pss_datapath.sv
module pss_datapath
  import pss_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  pwrState_e         curState,
  input  seqStrobe_t        strb,
  input  logic              nvmWakeEn,
  input  logic              nvmSideEn,
  output logic              nvmStart,
  output logic              phyRst,
  output logic [MODE_W-1:0] phyMode,
  output logic              linkL1
);

  logic     startQ, phyRstQ, wakeQ, sideQ, lowPowerOk;
  phyMode_e modeD;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startQ  <= 1'b0;
      phyRstQ <= 1'b1;
      wakeQ   <= 1'b0;
      sideQ   <= 1'b0;
    end else begin
      startQ <= strb.startRead;
      if (strb.assertRst)       phyRstQ <= 1'b1;
      else if (strb.releaseRst) phyRstQ <= 1'b0;
      if (strb.latchNvm) begin
        wakeQ <= nvmWakeEn;
        sideQ <= nvmSideEn;
      end
    end
  end

  always_comb begin
    lowPowerOk = wakeQ || sideQ;
    modeD      = PHY_OFF;
    if (!phyRstQ) begin
      unique case (curState)
        PS_D0A:         modeD = PHY_FULL;
        PS_D3, PS_D0U:  modeD = lowPowerOk ? PHY_LOW : PHY_OFF;
        default:        modeD = PHY_OFF;
      endcase
    end
  end

  assign nvmStart = startQ;
  assign phyRst   = phyRstQ;
  assign phyMode  = modeD;
  assign linkL1   = (curState == PS_D3);

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    startQ |=> !startQ); // R4

  AST_RST_IN_READ: assert property (@(posedge clk) disable iff (!rstN)
    (curState == PS_READ) |-> phyRstQ); // R5

  AST_RST_FREE_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    (curState == PS_D0A) |-> !phyRstQ); // R7

endmodule

// File: rtl/pwr_state_seq.sv
module pwr_state_seq
  import pss_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrValid,
  input  logic [1:0]  cfgWrState,
  input  logic        cmdWrValid,
  input  logic        cmdMemEn,
  input  logic        cmdIoEn,
  output logic        nvmStart,
  input  logic        nvmDone,
  input  logic        nvmWakeEn,
  input  logic        nvmSideEn,
  output logic        phyRst,
  output logic [1:0]  phyMode,
  output logic        linkL1,
  output logic [1:0]  pwrState
);

  pwrState_e  curState;
  seqStrobe_t strb;

  pss_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWrValid (cfgWrValid),
    .cfgWrState (cfgWrState),
    .cmdWrValid (cmdWrValid),
    .cmdMemEn   (cmdMemEn),
    .cmdIoEn    (cmdIoEn),
    .nvmDone    (nvmDone),
    .curState   (curState),
    .strb       (strb)
  );

  pss_datapath uData (
    .clk       (clk),
    .rstN      (rstN),
    .curState  (curState),
    .strb      (strb),
    .nvmWakeEn (nvmWakeEn),
    .nvmSideEn (nvmSideEn),
    .nvmStart  (nvmStart),
    .phyRst    (phyRst),
    .phyMode   (phyMode),
    .linkL1    (linkL1)
  );

  assign pwrState = curState;

endmodule

// File: tb/tb_pwr_state_seq.sv
`timescale 1ns/1ps
module tb_pwr_state_seq;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWrValid = 1'b0;
  logic [1:0] cfgWrState = 2'b00;
  logic       cmdWrValid = 1'b0;
  logic       cmdMemEn = 1'b0;
  logic       cmdIoEn = 1'b0;
  logic       nvmDone = 1'b0;
  logic       nvmWakeEn = 1'b0;
  logic       nvmSideEn = 1'b0;
  logic       nvmStart, phyRst, linkL1;
  logic [1:0] phyMode, pwrState;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  pwr_state_seq dut (
    .clk(clk), .rstN(rstN),
    .cfgWrValid(cfgWrValid), .cfgWrState(cfgWrState),
    .cmdWrValid(cmdWrValid), .cmdMemEn(cmdMemEn), .cmdIoEn(cmdIoEn),
    .nvmStart(nvmStart), .nvmDone(nvmDone),
    .nvmWakeEn(nvmWakeEn), .nvmSideEn(nvmSideEn),
    .phyRst(phyRst), .phyMode(phyMode), .linkL1(linkL1),
    .pwrState(pwrState)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic expectAll(input string req, input int st, input int rst,
                           input int mode, input int l1);
    check(req, "pwrState", pwrState, st);
    check(req, "phyRst", phyRst, rst);
    check(req, "phyMode", phyMode, mode);
    check(req, "linkL1", linkL1, l1);
  endtask

  task automatic cfgWrite(input logic [1:0] v);
    cfgWrValid = 1'b1; cfgWrState = v;
    step();
    cfgWrValid = 1'b0;
  endtask

  task automatic cmdWrite(input logic mem, input logic io);
    cmdWrValid = 1'b1; cmdMemEn = mem; cmdIoEn = io;
    step();
    cmdWrValid = 1'b0; cmdMemEn = 1'b0; cmdIoEn = 1'b0;
  endtask

  task automatic nvmFinish(input logic wake, input logic side);
    nvmDone = 1'b1; nvmWakeEn = wake; nvmSideEn = side;
    step();
    nvmDone = 1'b0; nvmWakeEn = 1'b0; nvmSideEn = 1'b0;
  endtask

  task automatic testReset();
    rstN = 1'b0;
    step(2);
    expectAll("R1", 3, 1, 0, 0);
    check("R1", "nvmStart", nvmStart, 0);
  endtask

  task automatic testInitialRead();
    rstN = 1'b1;
    step();
    check("R2", "nvmStart after reset", nvmStart, 1);
    step();
    check("R2", "nvmStart one cycle", nvmStart, 0);
    cmdWrite(1'b1, 1'b1);
    check("R2", "access while pending", pwrState, 3);
    check("R2", "phyRst while pending", phyRst, 1);
    nvmFinish(1'b1, 1'b0);
    expectAll("R2", 3, 0, 1, 0);
  endtask

  task automatic testGoActive();
    cmdWrite(1'b0, 1'b0);
    check("R7", "empty command write", pwrState, 3);
    step(40);
    check("R6", "uninit dwell", pwrState, 3);
    cmdWrite(1'b0, 1'b1);
    expectAll("R7", 0, 0, 2, 0);
  endtask

  task automatic testActiveIgnores();
    cfgWrite(2'b01);
    check("R8", "01 in active", pwrState, 0);
    cfgWrite(2'b10);
    check("R8", "10 in active", pwrState, 0);
    cfgWrite(2'b00);
    check("R8", "00 in active", pwrState, 0);
    cmdWrite(1'b1, 1'b0);
    check("R8", "command in active", pwrState, 0);
    nvmFinish(1'b0, 1'b0);
    check("R10", "stray done in active", pwrState, 0);
  endtask

  task automatic testEnterSleep(input int expMode);
    cfgWrite(2'b11);
    expectAll("R3", 1, 0, expMode, 1);
    check("R9", "sleep mode from latched bits", phyMode, expMode);
  endtask

  task automatic testSleepIgnores();
    cfgWrite(2'b11);
    check("R8", "11 in sleep", pwrState, 1);
    cfgWrite(2'b10);
    check("R8", "10 in sleep", pwrState, 1);
    cmdWrite(1'b1, 1'b1);
    check("R8", "command in sleep", pwrState, 1);
    nvmFinish(1'b0, 1'b0);
    check("R10", "stray done in sleep", pwrState, 1);
    step(100);
    check("R4", "sleep dwell", pwrState, 1);
  endtask

  task automatic testExit(input logic wake, input logic side, input int expMode);
    cfgWrite(2'b00);
    check("R4", "nvmStart on entry", nvmStart, 1);
    expectAll("R4", 2, 1, 0, 0);
    step();
    check("R4", "nvmStart one cycle", nvmStart, 0);
    cfgWrite(2'b11);
    cmdWrite(1'b1, 1'b0);
    step(5);
    check("R5", "read holds", pwrState, 2);
    check("R5", "phyRst held", phyRst, 1);
    nvmFinish(wake, side);
    expectAll("R5", 3, 0, expMode, 0);
    check("R6", "uninit mode", phyMode, expMode);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    testReset();
    testInitialRead();
    testGoActive();
    testActiveIgnores();
    testEnterSleep(1);          // wake bit latched from first read
    testSleepIgnores();
    testExit(1'b0, 1'b0, 0);    // both bits clear: PHY off
    cmdWrite(1'b1, 1'b0);
    expectAll("R7", 0, 0, 2, 0);
    testEnterSleep(0);
    check("R9", "sleep off after clear result", phyMode, 0);
    testExit(1'b0, 1'b1, 1);    // sideband only: reduced
    nvmFinish(1'b0, 1'b0);
    check("R10", "stray done in uninit", phyMode, 1);
    cmdWrite(1'b1, 1'b0);
    cfgWrite(2'b11);
    check("R10", "latched bits kept", phyMode, 1);
    testReset();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule